// File: doc/BRIEF.md
# Signed-Digit to BCD Converter

This block turns a word of signed decimal digits, each held as a small two's-complement number in the range -9 to +9, into an ordinary unsigned BCD word. It is used at the end of a carry-free decimal adder, where the redundant result must be made canonical before it is stored or compared.

The conversion has three steps. First, each digit gives a local borrow status: it starts a borrow when it is negative, and it passes an incoming borrow on when it is zero. Second, a logarithmic-depth parallel-prefix tree resolves the borrow that enters every digit. Third, each digit gets one of four constant corrections, chosen from its sign and its incoming borrow. A borrow leaving the top digit means the whole value was negative. In that case it is reported on a flag, and the BCD word holds the ten's complement of the magnitude. The block is purely combinational.

Top module: `sd2bcd_conv`

## Requirements
- R1: Input digit k sits at `sd_i[5k+4:5k]` as 5-bit two's complement. Output digit k sits at `bcd_o[4k+3:4k]` as 4-bit BCD. Digit 0 is the least significant.
- R2: When every input digit lies in -9..9, every output digit lies in 0..9.
- R3: The BCD value, minus `neg_o`·10^8, equals the signed value Σ sd_k·10^k.
- R4: With no incoming borrow, a digit that is zero or positive is passed through unchanged. An all-zero word gives an all-zero result with `neg_o` low.
- R5: With no incoming borrow, a negative digit d gives d+10.
- R6: With an incoming borrow, a positive digit d gives d-1.
- R7: With an incoming borrow, a digit d that is zero or negative gives d+9.
- R8: A negative digit sends a borrow into the next digit. A zero digit forwards its incoming borrow. A positive digit absorbs the borrow. A run of zero digits above a negative digit therefore becomes a run of nines.
- R9: `neg_o` is the borrow out of the top digit. It is high exactly when the signed value is negative.
- R10: Digit 0 receives no borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sd_i | input | 40 | Signed-digit word, 8 digits of 5 bits each |
| bcd_o | output | 32 | BCD word, 8 digits of 4 bits each |
| neg_o | output | 1 | High when the signed value is negative |

## Verification
The bench drives every digit value in -9..9 at a middle position, both with a borrow forced in from below and with none. A wrong correction constant, or a swapped sign or zero test, would produce a digit off by one or by ten. It also drives long runs of zero digits above a single negative digit. A prefix tree with a wrong span or a missing stage would lose the borrow partway up, so the result would not be all nines. Top-digit and bottom-digit sweeps, together with random whole words, check the negative flag and the ten's-complement form against a value computed with plain integer arithmetic.

// File: rtl/sd2bcd_pkg.sv
package sd2bcd_pkg;
  localparam int unsigned DIGITS_DEF = 8;
  localparam int unsigned SD_W_DEF   = 5;
  localparam int unsigned BCD_W_DEF  = 4;
endpackage

// File: rtl/sd2bcd_gp.sv
module sd2bcd_gp #(
  parameter int unsigned SD_W = sd2bcd_pkg::SD_W_DEF
) (
  input  logic [SD_W-1:0] sd_i,
  output logic            gen_o,
  output logic            prop_o
);
  assign gen_o  = sd_i[SD_W-1];
  assign prop_o = ~|sd_i;
endmodule

// File: rtl/sd2bcd_prefix.sv
module sd2bcd_prefix #(
  parameter int unsigned N = sd2bcd_pkg::DIGITS_DEF
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] bin_o,
  output logic         bout_o
);
  localparam int unsigned LEVELS = $clog2(N);

  logic [N-1:0] gl [LEVELS+1];
  logic [N-1:0] pl [LEVELS];

  assign gl[0] = gen_i;
  assign pl[0] = prop_i;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int unsigned DIST = 1 << lv;
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= DIST) begin : g_comb
        assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-DIST]);
        if (lv + 1 < LEVELS) begin : g_p
          assign pl[lv+1][i] = pl[lv][i] & pl[lv][i-DIST];
        end
      end else begin : g_pass
        assign gl[lv+1][i] = gl[lv][i];
        if (lv + 1 < LEVELS) begin : g_p
          assign pl[lv+1][i] = pl[lv][i];
        end
      end
    end
  end

  // borrow into digit 0 is zero
  assign bin_o  = {gl[LEVELS][N-2:0], 1'b0};
  assign bout_o = gl[LEVELS][N-1];
endmodule

// File: rtl/sd2bcd_fix.sv
module sd2bcd_fix #(
  parameter int unsigned SD_W  = sd2bcd_pkg::SD_W_DEF,
  parameter int unsigned BCD_W = sd2bcd_pkg::BCD_W_DEF
) (
  input  logic [SD_W-1:0]  sd_i,
  input  logic             bin_i,
  output logic [BCD_W-1:0] bcd_o
);
  logic [BCD_W-1:0] low, dec1, add9, add10;
  logic             is_neg, is_zero;

  // candidates computed in parallel, modulo 2^BCD_W
  assign low     = sd_i[BCD_W-1:0];
  assign dec1    = low - BCD_W'(1);
  assign add9    = low + BCD_W'(9);
  assign add10   = low + BCD_W'(10);
  assign is_neg  = sd_i[SD_W-1];
  assign is_zero = ~|sd_i;

  always_comb begin
    if (bin_i) begin
      bcd_o = (is_neg || is_zero) ? add9 : dec1;
    end else begin
      bcd_o = is_neg ? add10 : low;
    end
  end
endmodule

// File: rtl/sd2bcd_conv.sv
module sd2bcd_conv #(
  parameter int unsigned DIGITS = sd2bcd_pkg::DIGITS_DEF,
  parameter int unsigned SD_W   = sd2bcd_pkg::SD_W_DEF,
  parameter int unsigned BCD_W  = sd2bcd_pkg::BCD_W_DEF
) (
  input  logic [DIGITS*SD_W-1:0]  sd_i,
  output logic [DIGITS*BCD_W-1:0] bcd_o,
  output logic                    neg_o
);
  logic [DIGITS-1:0] gen, prop, bin;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    sd2bcd_gp #(.SD_W(SD_W)) u_gp (
      .sd_i   (sd_i[k*SD_W +: SD_W]),
      .gen_o  (gen[k]),
      .prop_o (prop[k])
    );
    sd2bcd_fix #(.SD_W(SD_W), .BCD_W(BCD_W)) u_fix (
      .sd_i  (sd_i[k*SD_W +: SD_W]),
      .bin_i (bin[k]),
      .bcd_o (bcd_o[k*BCD_W +: BCD_W])
    );
  end

  sd2bcd_prefix #(.N(DIGITS)) u_prefix (
    .gen_i  (gen),
    .prop_i (prop),
    .bin_o  (bin),
    .bout_o (neg_o)
  );
endmodule

// File: rtl/sd2bcd_conv_chk.sv
module sd2bcd_conv_chk #(
  parameter int unsigned DIGITS = sd2bcd_pkg::DIGITS_DEF,
  parameter int unsigned SD_W   = sd2bcd_pkg::SD_W_DEF,
  parameter int unsigned BCD_W  = sd2bcd_pkg::BCD_W_DEF
) (
  input logic [DIGITS*SD_W-1:0]  sd_i,
  input logic [DIGITS*BCD_W-1:0] bcd_o,
  input logic                    neg_o
);
  logic            in_ok;
  logic [SD_W-1:0] top_d, low_d;
  logic [BCD_W:0]  low_exp;

  assign top_d   = sd_i[(DIGITS-1)*SD_W +: SD_W];
  assign low_d   = sd_i[SD_W-1:0];
  assign low_exp = low_d[SD_W-1] ? (BCD_W+1)'(low_d[BCD_W-1:0]) + (BCD_W+1)'(10) - (BCD_W+1)'(16)
                                 : (BCD_W+1)'(low_d[BCD_W-1:0]);

  always_comb begin
    in_ok = 1'b1;
    for (int k = 0; k < int'(DIGITS); k++) begin
      if ($signed(sd_i[k*SD_W +: SD_W]) < -9 || $signed(sd_i[k*SD_W +: SD_W]) > 9) in_ok = 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < int'(DIGITS); k++) begin
      if (in_ok) AST_DIGIT_RANGE: assert (bcd_o[k*BCD_W +: BCD_W] <= BCD_W'(9)); // R2
    end
    if (sd_i == '0) AST_ZERO_WORD: assert (bcd_o == '0 && !neg_o); // R4
    if (top_d[SD_W-1]) AST_TOP_NEG_FLAG: assert (neg_o); // R9
    if (!top_d[SD_W-1] && top_d != '0) AST_TOP_POS_FLAG: assert (!neg_o); // R9
    if (in_ok) AST_LSD_NO_BORROW: assert ((BCD_W+1)'(bcd_o[BCD_W-1:0]) == low_exp); // R10
  end
endmodule

bind sd2bcd_conv sd2bcd_conv_chk #(.DIGITS(DIGITS), .SD_W(SD_W), .BCD_W(BCD_W)) u_chk (
  .sd_i  (sd_i),
  .bcd_o (bcd_o),
  .neg_o (neg_o)
);

// File: tb/sd2bcd_conv_bench.sv
module sd2bcd_conv_bench;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ND*5-1:0] sd;
  logic [ND*4-1:0] bcd;
  logic            neg;
  logic signed [4:0] dg [ND];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd2bcd_conv u_sd2bcd_conv (.sd_i(sd), .bcd_o(bcd), .neg_o(neg));

  task automatic drive();
    @(negedge clk);
    for (int k = 0; k < ND; k++) sd[k*5 +: 5] = dg[k];
    #5;
  endtask

  task automatic clear_digits();
    for (int k = 0; k < ND; k++) dg[k] = 5'sd0;
  endtask

  task automatic check_word(input string tag);
    longint v = 0;
    longint p = 1;
    longint u;
    logic [ND*4-1:0] exp_bcd;
    logic exp_neg;
    bit range_ok = 1'b1;
    for (int k = 0; k < ND; k++) begin
      v += longint'(dg[k]) * p;
      p *= 10;
    end
    exp_neg = (v < 0);
    u = v + (exp_neg ? 64'sd100000000 : 64'sd0);
    for (int k = 0; k < ND; k++) begin
      exp_bcd[k*4 +: 4] = 4'(u % 10);
      u = u / 10;
      if (bcd[k*4 +: 4] > 4'd9) range_ok = 1'b0;
    end
    checks++;
    if (bcd !== exp_bcd || neg !== exp_neg || !range_ok) begin
      failures++;
      $display("FAIL %s: sd=%h actual bcd=%h neg=%b expected bcd=%h neg=%b",
               tag, sd, bcd, neg, exp_bcd, exp_neg);
    end
  endtask

  initial begin
    clear_digits();
    sd = '0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (bcd !== '0 || neg !== 1'b0) begin
      failures++;
      $display("FAIL R4 reset-zero: actual bcd=%h neg=%b expected 0 0", bcd, neg);
    end
    rst_ni = 1'b1;

    // R1: fixed pattern, digits k+1 at position k
    for (int k = 0; k < ND; k++) dg[k] = 5'(k + 1);
    drive();
    check_word("R1 encoding");

    // R8: borrow through a zero run gives nines
    clear_digits();
    dg[0] = -5'sd1;
    drive();
    check_word("R8 zero run R9");
    dg[7] = 5'sd1;
    drive();
    check_word("R8 absorbed by top");
    clear_digits();
    dg[2] = -5'sd3; dg[6] = 5'sd2;
    drive();
    check_word("R8 partial run");

    // Per-digit sweep at position 3, with and without borrow in
    for (int b = 0; b < 2; b++) begin
      for (int d = -9; d <= 9; d++) begin
        string tag;
        clear_digits();
        dg[5] = 5'sd4;
        if (b == 1) dg[2] = -5'sd1;
        dg[3] = 5'(d);
        if (b == 1) tag = (d > 0) ? "R6 borrow pos" : "R7 borrow nonpos";
        else        tag = (d < 0) ? "R5 neg no borrow" : "R4 pass";
        drive();
        check_word(tag);
      end
    end

    // R10 bottom digit and R9 top digit sweeps
    for (int d = -9; d <= 9; d++) begin
      clear_digits();
      dg[0] = 5'(d); dg[4] = 5'sd1;
      drive();
      check_word("R10 lsd");
      clear_digits();
      dg[7] = 5'(d); dg[1] = 5'sd9;
      drive();
      check_word("R9 top sign");
    end

    // R2 / R3: random whole words
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < ND; k++) dg[k] = 5'($signed($urandom_range(0, 18)) - 9);
      drive();
      check_word("R3 R2 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule